// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block is the operating-state keeper for a serial peripheral core. A host writes a two-bit state code into a small register, and the block decides whether the attached data engine is held cleared, shifting, or frozen with its serial clock stopped while the host tops up the transmit FIFO. Bit 2 of the same register is a read-only valid flag. After each accepted state change it reads 0 for a fixed settle time. The host must poll it before and after every transition.

A normal transfer walks RESET, RUN, PAUSE (the host preloads data here), RUN again, and back to RESET at the end. Leaving PAUSE for RESET is deliberately awkward: the host has to write the clear code twice in a row. The first write moves the machine to PAUSE_ARMED and the second completes the drop to RESET. A separate software-reset register forces the core back to RESET from any state.

The machine has four states. RESET (code 0) asserts the engine clear. RUN (code 1) enables the serial clock and FIFO access. PAUSE (code 3) keeps FIFO access and stops the clock. PAUSE_ARMED also reads back as code 3 and has one clear write pending. The transitions are:
- RESET or RUN to RESET, RUN or PAUSE on a write of code 0, 1 or 3.
- PAUSE to RUN or PAUSE on a write of 1 or 3.
- PAUSE to PAUSE_ARMED on a write of 2.
- PAUSE_ARMED to RESET on a write of 2.
- PAUSE_ARMED to RUN or PAUSE on a write of 1 or 3.
- PAUSE_ARMED back to PAUSE on a write of 0, which cancels the pending clear.
- Any state to RESET on a software reset.

Top module: `periph_run_ctrl`

## Requirements
- R1: After rst_n is released, the state register reads code 0 with the valid flag set, eng_clear is 1, and sclk_en and fifo_fill_en are 0.
- R2: When reg_addr is 0, reg_rdata carries the state code in bits [1:0] (0 reset, 1 run, 3 pause) and the valid flag in bit 2, with all higher bits 0. When reg_addr is 1, reg_rdata reads all zeros. Bits of reg_wdata above bit 1 have no effect on a state write.
- R3: An accepted state write clears the valid flag from the cycle after the write edge. The flag stays clear for exactly 3 cycles and then reads 1.
- R4: A state write made while the valid flag reads 0 is ignored.
- R5: In RESET or RUN, a single write of code 0, 1 or 3 moves to that state. A write of code 2 there changes nothing and leaves the valid flag at 1.
- R6: From PAUSE, the first write of code 2 keeps the code at 3 and the valid flag at 1. The next state write, if it is also code 2, moves to RESET and starts the settle time.
- R7: While a clear is pending, a write of code 0 cancels it and stays in PAUSE without settling. A write of 1 or 3 cancels it and takes effect as a normal transition.
- R8: In PAUSE with no clear pending, a write of code 0 is ignored.
- R9: A write to address 1 with bit 0 set forces RESET from any state, even while the flag is 0. It also cancels any pending clear and starts the 3-cycle settle time. A write to address 1 with bit 0 clear has no effect.
- R10: eng_clear is 1 exactly in reset. sclk_en is 1 exactly in run. fifo_fill_en is 1 in run and in pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the state register, 1 the software-reset register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| eng_clear | output | 1 | Synchronous clear to engine counters and FIFOs |
| sclk_en | output | 1 | Serial clock and shift enable |
| fifo_fill_en | output | 1 | Host may push or pop FIFO data |

## Verification
Several rules are checked by assertions on every cycle. An accepted change always drops the valid flag on the next cycle. The state holds across any write made while the flag is low. PAUSE never reaches RESET in one step except through the software reset. A software reset always lands in a cleared, unsettled RESET. The engine clear and FIFO access are never both on. Only the bench scenarios can show the rest: the exact three-cycle settle length, the arm-then-complete order of the clear code, cancellation by each kind of intervening write, and the way the code-2, code-0 and upper data bits are ignored. The bench compares these every clock against its own model of the register.

// File: rtl/prc_pkg.sv
package prc_pkg;

    // Host-visible state codes
    localparam logic [1:0] CODE_RESET = 2'd0;
    localparam logic [1:0] CODE_RUN   = 2'd1;
    localparam logic [1:0] CODE_CLEAR = 2'd2;
    localparam logic [1:0] CODE_PAUSE = 2'd3;

    // Register addresses and field positions
    localparam logic REG_STATE  = 1'b0;
    localparam logic REG_SWRST  = 1'b1;
    localparam int   VALID_BIT  = 2;

    typedef enum logic [1:0] {
        ST_RESET,
        ST_RUN,
        ST_PAUSE,
        ST_PAUSE_ARMED
    } run_state_e;

    function automatic logic [1:0] state_code(run_state_e s);
        logic [1:0] c;
        unique case (s)
            ST_RESET:       c = CODE_RESET;
            ST_RUN:         c = CODE_RUN;
            ST_PAUSE:       c = CODE_PAUSE;
            ST_PAUSE_ARMED: c = CODE_PAUSE;
            default:        c = CODE_RESET;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/prc_settle_timer.sv
module prc_settle_timer #(
    parameter int SETTLE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic settled
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign settled = (cnt == '0);

    // R3: an accepted change is never reported as settled on the next cycle
    a_r3_start_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !settled);

endmodule

// File: rtl/prc_state_fsm.sv
module prc_state_fsm
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_state,
    input  logic [1:0] wr_code,
    input  logic       settled,
    input  logic       sw_reset,
    output run_state_e state,
    output logic       accept
);
    run_state_e state_nx;
    logic       take;

    assign take = wr_state && settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        if (sw_reset) begin
            state_nx = ST_RESET;
            accept   = 1'b1;
        end else if (take) begin
            unique case (state)
                ST_RESET, ST_RUN: begin
                    unique case (wr_code)
                        CODE_RESET: begin state_nx = ST_RESET; accept = 1'b1; end
                        CODE_RUN:   begin state_nx = ST_RUN;   accept = 1'b1; end
                        CODE_PAUSE: begin state_nx = ST_PAUSE; accept = 1'b1; end
                        default:    state_nx = state;
                    endcase
                end
                ST_PAUSE: begin
                    unique case (wr_code)
                        CODE_RUN:   begin state_nx = ST_RUN;   accept = 1'b1; end
                        CODE_PAUSE: begin state_nx = ST_PAUSE; accept = 1'b1; end
                        CODE_CLEAR: state_nx = ST_PAUSE_ARMED;
                        default:    state_nx = ST_PAUSE;
                    endcase
                end
                ST_PAUSE_ARMED: begin
                    unique case (wr_code)
                        CODE_CLEAR: begin state_nx = ST_RESET; accept = 1'b1; end
                        CODE_RUN:   begin state_nx = ST_RUN;   accept = 1'b1; end
                        CODE_PAUSE: begin state_nx = ST_PAUSE; accept = 1'b1; end
                        default:    state_nx = ST_PAUSE;
                    endcase
                end
                default: state_nx = ST_RESET;
            endcase
        end
    end

    // R4: a write while unsettled leaves the state untouched
    a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state && !settled && !sw_reset) |=> (state == $past(state)));

    // R6: paused states reach reset in one step only through the software reset
    a_r6_pause_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESET && $past(state) == ST_PAUSE) |-> $past(sw_reset));

endmodule

// File: rtl/prc_gate_decode.sv
module prc_gate_decode
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  run_state_e state,
    output logic       eng_clear,
    output logic       sclk_en,
    output logic       fifo_fill_en
);
    always_comb begin
        eng_clear    = 1'b0;
        sclk_en      = 1'b0;
        fifo_fill_en = 1'b0;
        unique case (state)
            ST_RESET:       eng_clear = 1'b1;
            ST_RUN:         begin sclk_en = 1'b1; fifo_fill_en = 1'b1; end
            ST_PAUSE,
            ST_PAUSE_ARMED: fifo_fill_en = 1'b1;
            default:        eng_clear = 1'b1;
        endcase
    end

    // R10: FIFO access never overlaps an engine clear
    a_r10_clear_blocks_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        eng_clear |-> !fifo_fill_en);

endmodule

// File: rtl/periph_run_ctrl.sv
module periph_run_ctrl
    import prc_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SETTLE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              eng_clear,
    output logic              sclk_en,
    output logic              fifo_fill_en
);
    run_state_e state;
    logic       wr_state;
    logic       sw_reset;
    logic       settled;
    logic       accept;
    logic       unused_wdata_hi;

    assign wr_state        = reg_we && (reg_addr == REG_STATE);
    assign sw_reset        = reg_we && (reg_addr == REG_SWRST) && reg_wdata[0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:2];

    prc_state_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_state (wr_state),
        .wr_code  (reg_wdata[1:0]),
        .settled  (settled),
        .sw_reset (sw_reset),
        .state    (state),
        .accept   (accept)
    );

    prc_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .settled (settled)
    );

    prc_gate_decode u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .eng_clear    (eng_clear),
        .sclk_en      (sclk_en),
        .fifo_fill_en (fifo_fill_en)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_STATE) begin
            reg_rdata[1:0]       = state_code(state);
            reg_rdata[VALID_BIT] = settled;
        end
    end

    // R9: software reset always lands in a cleared, unsettled state
    a_r9_swreset_forces_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (eng_clear && !settled));

endmodule

// File: tb/periph_run_ctrl_test.sv
module periph_run_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 3;
    localparam int DW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          addr = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          ec, se, ff;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // reference model state
    int m_code  = 0;
    bit m_armed = 1'b0;
    int m_cnt   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_run_ctrl #(.DATA_W(DW), .SETTLE_CYC(SETTLE)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (we),
        .reg_addr     (addr),
        .reg_wdata    (wdata),
        .reg_rdata    (rdata),
        .eng_clear    (ec),
        .sclk_en      (se),
        .fifo_fill_en (ff)
    );

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(string tag);
        int exp_rd;
        exp_rd = (addr == 1'b1) ? 0 : (((m_cnt == 0) ? 4 : 0) + m_code);
        check(tag, "reg_rdata", int'(rdata), exp_rd);
        check(tag, "eng_clear", int'(ec), (m_code == 0) ? 1 : 0);
        check(tag, "sclk_en", int'(se), (m_code == 1) ? 1 : 0);
        check(tag, "fifo_fill_en", int'(ff), (m_code == 1 || m_code == 3) ? 1 : 0);
    endtask

    task automatic model_edge();
        bit v;
        bit acc;
        int c;
        v   = (m_cnt == 0);
        acc = 1'b0;
        c   = int'(wdata[1:0]);
        if (we && addr == 1'b1 && wdata[0]) begin
            m_code = 0; m_armed = 1'b0; acc = 1'b1;
        end else if (we && addr == 1'b0 && v) begin
            if (m_code == 3) begin
                if (c == 2) begin
                    if (m_armed) begin m_code = 0; m_armed = 1'b0; acc = 1'b1; end
                    else m_armed = 1'b1;
                end else if (c == 0) begin
                    m_armed = 1'b0;
                end else begin
                    m_code = c; m_armed = 1'b0; acc = 1'b1;
                end
            end else if (c != 2) begin
                m_code = c; acc = 1'b1;
            end
        end
        if (acc) m_cnt = SETTLE;
        else if (m_cnt > 0) m_cnt--;
    endtask

    task automatic step(bit w, bit a, logic [DW-1:0] d, string tag);
        @(negedge clk);
        we = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge();
        #2;
        compare_all(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, tag);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        idle(1, "R1");

        step(1, 0, 8'h02, "R5");          // clear code in reset: ignored
        step(1, 0, 8'h01, "R5");          // reset -> run
        idle(1, "R3");
        step(1, 0, 8'h00, "R4");          // write while unsettled
        idle(2, "R3");
        step(1, 0, 8'h02, "R5");          // clear code in run: ignored
        step(1, 0, 8'h03, "R10");         // run -> pause
        idle(3, "R3");
        step(1, 0, 8'h00, "R8");          // 0 in pause ignored
        step(1, 0, 8'h02, "R6");          // arm
        idle(1, "R6");
        step(1, 0, 8'h02, "R6");          // complete -> reset
        idle(3, "R6");

        step(1, 0, 8'h01, "R10"); idle(3, "R3");
        step(1, 0, 8'h03, "R10"); idle(3, "R3");
        step(1, 0, 8'h02, "R7");          // arm
        step(1, 0, 8'h00, "R7");          // cancel
        step(1, 0, 8'h02, "R7");          // arm again
        step(1, 0, 8'h01, "R7");          // cancel, go run
        idle(3, "R7");
        step(1, 0, 8'h03, "R7"); idle(3, "R7");
        step(1, 0, 8'h02, "R7");
        step(1, 0, 8'h03, "R7");          // cancel, re-enter pause with settle
        idle(3, "R7");
        step(1, 0, 8'h02, "R7");          // must only arm (pending was cleared)
        step(1, 0, 8'h00, "R7");
        idle(1, "R7");

        step(1, 1, 8'h00, "R9");          // sw-reset register, bit0 clear
        step(1, 1, 8'hFE, "R9");
        step(1, 0, 8'h01, "R9");          // pause -> run
        step(1, 1, 8'h01, "R9");          // sw reset during settle
        idle(4, "R9");
        step(1, 0, 8'h03, "R9"); idle(3, "R9");
        step(1, 0, 8'h02, "R9");          // arm
        step(1, 1, 8'h01, "R9");          // sw reset clears arm
        idle(3, "R9");
        step(1, 0, 8'h02, "R9");          // clear code in reset: ignored

        step(0, 1, 8'h00, "R2");          // read sw-reset register
        step(1, 0, 8'hF1, "R2");          // upper bits ignored -> run
        idle(3, "R2");
        step(0, 1, 8'h00, "R2");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule